// File: doc/BRIEF.md
# I2C Register-Bridge Transaction Sequencer

This block performs 64-bit register reads and writes on a remote device that sits behind an I2C link. It also verifies the remote status after every access. A requester supplies the direction, a 31-bit register address, the write data and a start strobe. The sequencer then drives a byte-level I2C master one command at a time: start, repeated start, byte write, byte read with ack or nack, and stop. When the transaction is over it returns read data and a one-cycle done together with a 2-bit result code.

The register address is shifted up by one bit to form a 32-bit command word. The freed bit 0 carries odd parity. A successful access is always followed by a read of the remote status register. If that register reports a fault, the sequencer reads two diagnostic registers and then writes zero to all three registers. It finishes with a remote-error result, and the captured values remain visible on outputs. A missing acknowledge on the main access or on the status poll ends the transaction at once with an I/O error.

Top module: `i2c_regbridge_seq`

## Requirements
- R1: For a read, the command word is `{addr, p}`, where `p` makes the number of one bits in the 32-bit word odd.
- R2: For a write, `p` makes the total number of one bits across the 64 data bits and the 32-bit command word odd.
- R3: A read issues the following commands, each one only after `bm_done` for the one before it:
  - START;
  - WRITE of `{DEV_ADDR,0}`;
  - four WRITEs of the command word, least significant byte first;
  - RSTART;
  - WRITE of `{DEV_ADDR,1}`;
  - seven READ_ACK and one READ_NACK;
  - STOP.

  The eight bytes read assemble least significant first into `rsp_rdata`. The op codes are START=0, RSTART=1, WRITE=2, READ_ACK=3, READ_NACK=4 and STOP=5.
- R4: A write issues START, the address byte `{DEV_ADDR,0}`, twelve WRITEs and STOP. The twelve bytes are the four command bytes followed by the eight data bytes, both least significant first.
- R5: After a successful access, a read transfer with the raw command 0x00060002 follows. If bit 61 of the returned value is clear, done is given with code 00 and the value appears on `diag_status`.
- R6: If status bit 61 is set, the sequencer performs the following steps and then gives done with code 10:
  - reads with raw commands 0x00060004 and 0x00060008, captured on `diag_error` and `diag_log`;
  - three write transfers carrying 0x00060002, 0x00060004 and 0x00060008, each followed by eight zero bytes.
- R7: `bm_ack_err` on any WRITE of the main access or of the status poll is followed by STOP. Done then comes with code 01, and no further transfer is made.
- R8: `req_start` is ignored from acceptance until done, and the request fields are latched at acceptance.
- R9: `rsp_done` lasts one cycle. `rsp_err` is 00 whenever done is low. `rsp_rdata` and the three diagnostic outputs clear when a request is accepted and hold until the next one.
- R10: While `bm_valid` is high and `bm_done` low, `bm_op` and `bm_byte` hold steady.
- R11: An unacknowledged byte during a diagnostic read or clearing write ends that transfer with STOP. The sequence continues, the affected diagnostic output stays zero, and the result is still 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_start | input | 1 | Request strobe, taken only when idle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 31 | Remote register address |
| req_wdata | input | 64 | Write data |
| rsp_rdata | output | 64 | Read data of the last read request |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 2 | 00 ok, 01 I/O error, 10 remote error; valid with done |
| diag_status | output | 64 | Status value captured by the poll |
| diag_error | output | 64 | Diagnostic value from command 0x60004 |
| diag_log | output | 64 | Diagnostic value from command 0x60008 |
| bm_valid | output | 1 | Byte-master command pending |
| bm_op | output | 3 | Byte-master operation code |
| bm_byte | output | 8 | Byte to transmit for WRITE |
| bm_done | input | 1 | Byte master finished the pending command |
| bm_rdata | input | 8 | Byte received for READ_ACK/READ_NACK |
| bm_ack_err | input | 1 | Byte not acknowledged, valid with bm_done |

## Verification
The bench builds the sequencer with `DEV_ADDR` set to 7'h5A and `ERR_BIT` left at 61. Because 7'h5A is not the default, the address bytes the bench expects for both directions cannot match by accident. The bench models the remote device and answers each read according to the command word it has just received. This makes the status-fault path, the diagnostic fetches and the clearing writes reachable. Nacks injected at chosen command positions, together with response latencies of zero to three cycles, cover the I/O-error path, the tolerant diagnostic path and the handshake hold.

// File: rtl/i2c_regbridge_seq.sv
module i2c_regbridge_seq #(
  parameter logic [6:0] DEV_ADDR = 7'h20,
  parameter int ERR_BIT = 61
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_start,
  input  logic        req_write,
  input  logic [30:0] req_addr,
  input  logic [63:0] req_wdata,
  output logic [63:0] rsp_rdata,
  output logic        rsp_done,
  output logic [1:0]  rsp_err,
  output logic [63:0] diag_status,
  output logic [63:0] diag_error,
  output logic [63:0] diag_log,
  output logic        bm_valid,
  output logic [2:0]  bm_op,
  output logic [7:0]  bm_byte,
  input  logic        bm_done,
  input  logic [7:0]  bm_rdata,
  input  logic        bm_ack_err
);
  localparam logic [2:0] OP_START = 3'd0, OP_RSTART = 3'd1, OP_WRITE = 3'd2,
                         OP_RD_ACK = 3'd3, OP_RD_NACK = 3'd4, OP_STOP = 3'd5;
  localparam logic [3:0] P_IDLE = 4'd0, P_START = 4'd1, P_ADDR_W = 4'd2, P_WR = 4'd3,
                         P_RSTART = 4'd4, P_ADDR_R = 4'd5, P_RD = 4'd6, P_STOP = 4'd7,
                         P_DONE = 4'd8;
  localparam logic [2:0] S_MAIN = 3'd0, S_STAT = 3'd1, S_ERR = 3'd2, S_LOG = 3'd3,
                         S_CLR0 = 3'd4, S_CLR1 = 3'd5, S_CLR2 = 3'd6;
  localparam logic [31:0] C_STAT = 32'h0006_0002, C_ERR = 32'h0006_0004,
                          C_LOG = 32'h0006_0008;
  localparam logic [1:0] E_OK = 2'd0, E_IO = 2'd1, E_REMOTE = 2'd2;

  logic [3:0]  phase;
  logic [2:0]  step;
  logic [3:0]  idx;
  logic        fail;
  logic        wr_q;
  logic [30:0] addr_q;
  logic [63:0] wdata_q;
  logic [63:0] rbuf;
  logic [1:0]  err_q;
  logic [31:0] cur_cmd;
  logic [63:0] cur_data;
  logic        cur_read;
  logic [3:0]  wr_last;
  logic        main_par;
  logic [7:0]  tx_byte;

  assign main_par = ~(^addr_q ^ (wr_q & ^wdata_q));

  always_comb begin
    case (step)
      S_MAIN:         cur_cmd = {addr_q, main_par};
      S_STAT, S_CLR0: cur_cmd = C_STAT;
      S_ERR, S_CLR1:  cur_cmd = C_ERR;
      default:        cur_cmd = C_LOG;
    endcase
  end

  assign cur_read = (step == S_MAIN) ? ~wr_q
                  : (step == S_STAT || step == S_ERR || step == S_LOG);
  assign cur_data = (step == S_MAIN) ? wdata_q : 64'd0;
  assign wr_last  = cur_read ? 4'd3 : 4'd11;
  assign tx_byte  = (idx < 4'd4) ? cur_cmd[{idx[1:0], 3'b000} +: 8]
                                 : cur_data[{idx[2:0] - 3'd4, 3'b000} +: 8];

  assign bm_valid = (phase != P_IDLE) && (phase != P_DONE);
  assign rsp_done = (phase == P_DONE);
  assign rsp_err  = rsp_done ? err_q : E_OK;

  always_comb begin
    case (phase)
      P_START:  bm_op = OP_START;
      P_RSTART: bm_op = OP_RSTART;
      P_RD:     bm_op = (idx == 4'd7) ? OP_RD_NACK : OP_RD_ACK;
      P_STOP:   bm_op = OP_STOP;
      default:  bm_op = OP_WRITE;
    endcase
    case (phase)
      P_ADDR_W: bm_byte = {DEV_ADDR, 1'b0};
      P_ADDR_R: bm_byte = {DEV_ADDR, 1'b1};
      P_WR:     bm_byte = tx_byte;
      default:  bm_byte = 8'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase       <= P_IDLE;
      step        <= S_MAIN;
      idx         <= '0;
      fail        <= 1'b0;
      wr_q        <= 1'b0;
      addr_q      <= '0;
      wdata_q     <= '0;
      rbuf        <= '0;
      err_q       <= E_OK;
      rsp_rdata   <= '0;
      diag_status <= '0;
      diag_error  <= '0;
      diag_log    <= '0;
    end else begin
      case (phase)
        P_IDLE: if (req_start) begin
          wr_q        <= req_write;
          addr_q      <= req_addr;
          wdata_q     <= req_wdata;
          rsp_rdata   <= '0;
          diag_status <= '0;
          diag_error  <= '0;
          diag_log    <= '0;
          step        <= S_MAIN;
          idx         <= '0;
          fail        <= 1'b0;
          phase       <= P_START;
        end
        P_DONE: phase <= P_IDLE;
        default: if (bm_done) begin
          case (phase)
            P_START:  phase <= P_ADDR_W;
            P_RSTART: phase <= P_ADDR_R;
            P_ADDR_W, P_ADDR_R: begin
              idx <= '0;
              if (bm_ack_err) begin
                fail  <= 1'b1;
                phase <= P_STOP;
              end else begin
                phase <= (phase == P_ADDR_W) ? P_WR : P_RD;
              end
            end
            P_WR: begin
              if (bm_ack_err) begin
                fail  <= 1'b1;
                phase <= P_STOP;
              end else if (idx == wr_last) begin
                idx   <= '0;
                phase <= cur_read ? P_RSTART : P_STOP;
              end else begin
                idx <= idx + 4'd1;
              end
            end
            P_RD: begin
              rbuf[{idx[2:0], 3'b000} +: 8] <= bm_rdata;
              if (idx == 4'd7) phase <= P_STOP;
              else idx <= idx + 4'd1;
            end
            default: begin
              idx   <= '0;
              fail  <= 1'b0;
              phase <= P_START;
              case (step)
                S_MAIN: begin
                  if (fail) begin
                    err_q <= E_IO;
                    phase <= P_DONE;
                  end else begin
                    if (!wr_q) rsp_rdata <= rbuf;
                    step <= S_STAT;
                  end
                end
                S_STAT: begin
                  if (fail) begin
                    err_q <= E_IO;
                    phase <= P_DONE;
                  end else begin
                    diag_status <= rbuf;
                    if (rbuf[ERR_BIT]) begin
                      step <= S_ERR;
                    end else begin
                      err_q <= E_OK;
                      phase <= P_DONE;
                    end
                  end
                end
                S_ERR: begin
                  if (!fail) diag_error <= rbuf;
                  step <= S_LOG;
                end
                S_LOG: begin
                  if (!fail) diag_log <= rbuf;
                  step <= S_CLR0;
                end
                S_CLR0: step <= S_CLR1;
                S_CLR1: step <= S_CLR2;
                default: begin
                  err_q <= E_REMOTE;
                  phase <= P_DONE;
                end
              endcase
            end
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/i2c_regbridge_seq_chk.sv
module i2c_regbridge_seq_chk #(
  parameter int ERR_BIT = 61
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rsp_done,
  input logic [1:0]  rsp_err,
  input logic [63:0] diag_status,
  input logic        bm_valid,
  input logic        bm_done,
  input logic [2:0]  bm_op,
  input logic [7:0]  bm_byte
);
  assert_cmd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bm_valid && !bm_done |=> bm_valid && $stable(bm_op) && $stable(bm_byte));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  assert_code_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> rsp_err != 2'b11);

  assert_code_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_done |-> rsp_err == 2'b00);

  assert_no_bus_at_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> !bm_valid);

  assert_remote_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done && rsp_err == 2'b10 |-> diag_status[ERR_BIT]);

  assert_ok_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done && rsp_err == 2'b00 |-> !diag_status[ERR_BIT]);

  assert_opens_with_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bm_valid) |-> bm_op == 3'd0);
endmodule

bind i2c_regbridge_seq i2c_regbridge_seq_chk #(.ERR_BIT(ERR_BIT)) u_chk (.*);

// File: tb/test_i2c_regbridge_seq.sv
module test_i2c_regbridge_seq;
  localparam logic [6:0] DA = 7'h5A;
  localparam logic [2:0] OP_START = 3'd0, OP_RSTART = 3'd1, OP_WRITE = 3'd2,
                         OP_RD_ACK = 3'd3, OP_RD_NACK = 3'd4, OP_STOP = 3'd5;
  localparam logic [31:0] C_STAT = 32'h0006_0002, C_ERR = 32'h0006_0004,
                          C_LOG = 32'h0006_0008;
  localparam logic [63:0] FLAG = 64'h2000_0000_0000_0000;

  typedef struct packed {
    logic        wr;
    logic [30:0] addr;
    logic [63:0] wd;
    logic [63:0] rv;
    logic [3:0]  lat;
  } vec_t;

  localparam vec_t VECS [0:5] = '{
    '{1'b0, 31'h0000_1234, 64'h0, 64'h0123_4567_89AB_CDEF, 4'd0},
    '{1'b1, 31'h0000_0C10, 64'hFFFF_0000_1234_5678, 64'h0, 4'd1},
    '{1'b0, 31'h7FFF_FFFF, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 4'd2},
    '{1'b1, 31'h0000_0000, 64'h0, 64'h0, 4'd0},
    '{1'b1, 31'h0000_0001, 64'h1, 64'h0, 4'd3},
    '{1'b0, 31'h4000_0005, 64'h0, 64'hA5C3_0F00_FF11_2233, 4'd3}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_start = 1'b0;
  logic        req_write = 1'b0;
  logic [30:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic [63:0] rsp_rdata, diag_status, diag_error, diag_log;
  logic        rsp_done, bm_valid;
  logic [1:0]  rsp_err;
  logic [2:0]  bm_op;
  logic [7:0]  bm_byte;
  logic        bm_done = 1'b0;
  logic [7:0]  bm_rdata = '0;
  logic        bm_ack_err = 1'b0;

  i2c_regbridge_seq #(.DEV_ADDR(DA), .ERR_BIT(61)) i_i2c_regbridge_seq (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  logic [2:0] lg_op [0:255];
  logic [7:0] lg_by [0:255];
  int lg_n = 0;
  logic [2:0] ex_op [0:255];
  logic [7:0] ex_by [0:255];
  int ex_n = 0;
  int m_nack = -1;
  int m_lat = 0;
  logic [63:0] m_rv = '0, m_sv = '0, m_ev = '0, m_lv = '0;

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // Remote device and byte master model
  initial begin
    int pos;
    int rc;
    logic [31:0] cmd;
    logic [63:0] val;
    pos = 0; rc = 0; cmd = '0;
    forever begin
      @(negedge clk);
      bm_done = 1'b0;
      bm_ack_err = 1'b0;
      if (bm_valid) begin
        lg_op[lg_n] = bm_op;
        lg_by[lg_n] = bm_byte;
        lg_n++;
        if (bm_op == OP_START) pos = 0;
        if (bm_op == OP_RSTART) rc = 0;
        if (bm_op == OP_WRITE) begin
          if (pos >= 1 && pos <= 4) cmd[8*(pos-1) +: 8] = bm_byte;
          pos++;
        end
        if (cmd == C_STAT) val = m_sv;
        else if (cmd == C_ERR) val = m_ev;
        else if (cmd == C_LOG) val = m_lv;
        else val = m_rv;
        repeat (m_lat) @(negedge clk);
        bm_done = 1'b1;
        bm_ack_err = (bm_op == OP_WRITE) && (lg_n - 1 == m_nack);
        bm_rdata = 8'h00;
        if (bm_op == OP_RD_ACK || bm_op == OP_RD_NACK) begin
          bm_rdata = val[8*rc +: 8];
          rc++;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic logic [31:0] ecmd(input bit wr, input logic [30:0] a, input logic [63:0] d);
    bit p = 1'b1;
    for (int i = 0; i < 64; i++) if (wr && d[i]) p = !p;
    for (int i = 0; i < 31; i++) if (a[i]) p = !p;
    return {a, p};
  endfunction

  task automatic push(input logic [2:0] op, input logic [7:0] b);
    ex_op[ex_n] = op;
    ex_by[ex_n] = b;
    ex_n++;
  endtask

  task automatic xfer(input bit rd, input logic [31:0] cmd, input logic [63:0] d, output bit cut);
    cut = 1'b0;
    push(OP_START, 8'h00);
    push(OP_WRITE, {DA, 1'b0});
    if (ex_n - 1 == m_nack) begin push(OP_STOP, 8'h00); cut = 1'b1; return; end
    for (int i = 0; i < (rd ? 4 : 12); i++) begin
      push(OP_WRITE, (i < 4) ? cmd[8*i +: 8] : d[8*(i-4) +: 8]);
      if (ex_n - 1 == m_nack) begin push(OP_STOP, 8'h00); cut = 1'b1; return; end
    end
    if (rd) begin
      push(OP_RSTART, 8'h00);
      push(OP_WRITE, {DA, 1'b1});
      if (ex_n - 1 == m_nack) begin push(OP_STOP, 8'h00); cut = 1'b1; return; end
      for (int i = 0; i < 8; i++) push((i == 7) ? OP_RD_NACK : OP_RD_ACK, 8'h00);
    end
    push(OP_STOP, 8'h00);
  endtask

  task automatic run(input string rq, input bit wr, input logic [30:0] a, input logic [63:0] d,
                     input logic [63:0] rv, input logic [63:0] sv, input logic [63:0] ev,
                     input logic [63:0] lv, input int nk, input int lat, input bit poke);
    bit cut;
    logic [1:0] e_err;
    logic [63:0] e_rd, e_st, e_er, e_lg;
    int t, bad;
    e_rd = '0; e_st = '0; e_er = '0; e_lg = '0;
    ex_n = 0;
    m_nack = nk; m_lat = lat;
    m_rv = rv; m_sv = sv; m_ev = ev; m_lv = lv;
    xfer(!wr, ecmd(wr, a, d), wr ? d : 64'd0, cut);
    if (cut) e_err = 2'b01;
    else begin
      if (!wr) e_rd = rv;
      xfer(1'b1, C_STAT, 64'd0, cut);
      if (cut) e_err = 2'b01;
      else begin
        e_st = sv;
        if (sv[61]) begin
          xfer(1'b1, C_ERR, 64'd0, cut);
          if (!cut) e_er = ev;
          xfer(1'b1, C_LOG, 64'd0, cut);
          if (!cut) e_lg = lv;
          xfer(1'b0, C_STAT, 64'd0, cut);
          xfer(1'b0, C_ERR, 64'd0, cut);
          xfer(1'b0, C_LOG, 64'd0, cut);
          e_err = 2'b10;
        end else e_err = 2'b00;
      end
    end
    @(negedge clk);
    lg_n = 0;
    req_write = wr; req_addr = a; req_wdata = d; req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    check(diag_status == 0 && diag_error == 0 && diag_log == 0 && rsp_rdata == 0,
          "R9", {rq, " outputs cleared on accept"}, diag_status | diag_error | diag_log | rsp_rdata, 64'd0);
    if (poke) begin
      repeat (5) @(negedge clk);
      req_write = !wr; req_addr = ~a; req_wdata = ~d; req_start = 1'b1;
      @(negedge clk);
      req_start = 1'b0;
    end
    t = 0;
    while (!rsp_done && t < 20000) begin @(negedge clk); t++; end
    check(rsp_done, rq, "done reached", 64'(rsp_done), 64'd1);
    check(rsp_err == e_err, rq, "result code", 64'(rsp_err), 64'(e_err));
    check(rsp_rdata == e_rd, rq, "read data", rsp_rdata, e_rd);
    check(diag_status == e_st, rq, "status capture", diag_status, e_st);
    check(diag_error == e_er, rq, "error capture", diag_error, e_er);
    check(diag_log == e_lg, rq, "log capture", diag_log, e_lg);
    check(lg_n == ex_n, rq, "command count", 64'(lg_n), 64'(ex_n));
    bad = -1;
    for (int i = 0; i < ex_n && i < lg_n; i++)
      if (bad < 0 && (lg_op[i] != ex_op[i] || (ex_op[i] == OP_WRITE && lg_by[i] != ex_by[i])))
        bad = i;
    if (bad >= 0)
      check(1'b0, rq, $sformatf("command %0d op/byte", bad),
            64'({lg_op[bad], lg_by[bad]}), 64'({ex_op[bad], ex_by[bad]}));
    else check(1'b1, rq, "command sequence", 64'd0, 64'd0);
    @(negedge clk);
    check(!rsp_done && rsp_err == 2'b00, "R9", {rq, " done single cycle"}, 64'(rsp_done), 64'd0);
    m_nack = -1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!bm_valid && !rsp_done && rsp_err == 0, "R9", "reset idle", 64'({bm_valid, rsp_done, rsp_err}), 64'd0);
    check(rsp_rdata == 0 && diag_status == 0 && diag_error == 0 && diag_log == 0,
          "R9", "reset outputs", rsp_rdata | diag_status, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!bm_valid, "R9", "idle after reset", 64'(bm_valid), 64'd0);

    // Vector table: R1/R3 reads, R2/R4 writes, R5 clean status, R10 varied latency
    for (int v = 0; v < 6; v++)
      run(VECS[v].wr ? "R2 R4 R5 R10" : "R1 R3 R5 R10", VECS[v].wr, VECS[v].addr, VECS[v].wd,
          VECS[v].rv, 64'h0000_0000_0000_0042, 64'h0, 64'h0, -1, int'(VECS[v].lat), 1'b0);

    // R6: status fault after read and after write
    run("R6", 1'b0, 31'h0000_0C20, 64'h0, 64'h1122_3344_5566_7788,
        FLAG | 64'h77, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, -1, 1, 1'b0);
    run("R6", 1'b1, 31'h0000_0D00, 64'hDEAD_BEEF_0000_0001, 64'h0,
        FLAG | 64'hFFFF_0000_0000_0000, 64'hABCD, 64'h1234, -1, 2, 1'b0);
    // R7: nack on a command byte, on the read address, in the status poll
    run("R7", 1'b0, 31'h0000_0C30, 64'h0, 64'h99, 64'h0, 64'h0, 64'h0, 3, 0, 1'b0);
    run("R7", 1'b0, 31'h0000_0C34, 64'h0, 64'h99, 64'h0, 64'h0, 64'h0, 7, 1, 1'b0);
    run("R7", 1'b1, 31'h0000_0C38, 64'h5, 64'h0, 64'h0, 64'h0, 64'h0, 16, 0, 1'b0);
    run("R7", 1'b1, 31'h0000_0C3C, 64'h5, 64'h0, 64'h0, 64'h0, 64'h0, 1, 0, 1'b0);
    // R11: nack on the error-register read address, then on a clearing write byte
    run("R11", 1'b0, 31'h0000_0C40, 64'h0, 64'h1, FLAG, 64'hEEEE, 64'hCCCC, 35, 0, 1'b0);
    run("R11", 1'b0, 31'h0000_0C44, 64'h0, 64'h2, FLAG, 64'hEEEE, 64'hCCCC, 72, 0, 1'b0);
    // R8: start strobe during a transaction is ignored
    run("R8", 1'b0, 31'h0000_0C48, 64'h0, 64'h0F0E_0D0C_0B0A_0908, 64'h0, 64'h0, 64'h0, -1, 2, 1'b1);
    run("R8", 1'b1, 31'h0000_0C4C, 64'h0102_0304_0506_0708, 64'h0, FLAG, 64'h3, 64'h4, -1, 1, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule